// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Arbiter

This block sits between a group of peripheral interrupt sources and a CPU core. It takes sixteen maskable requests, a non-maskable request and an address-break request. From these it picks at most one request to hand to the core. Each maskable source is qualified by its own enable bit. Each also carries a one-bit priority level, so it belongs to either a low group or a high group.

The core supplies two mask bits from its condition-code register, a primary mask and a secondary mask. Together they decide which groups may be taken. The non-maskable and address-break requests ignore both masks. A request is taken only at an instruction boundary, which the core signals with a strobe. When a request is taken, the block gives the core three things for one cycle: an accept pulse, the vector number of the chosen source, and a command to set both mask bits. Saving state to the stack and fetching from the vector table are left to the core.

Top module: `irq_arbiter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `take` and `set_masks` are 0, and no earlier non-maskable edge is remembered.
- R2: A maskable source whose `src_en` bit is 0 is never taken, even if its request is high.
- R3: When any enabled high-level request (`src_lvl` bit = 1) is eligible, it is chosen ahead of every low-level request. The low-level requests stay pending.
- R4: Among eligible requests of the same level, the one with the lowest source index wins.
- R5: A low-level request is eligible only while `mask_i` is 0.
- R6: A high-level request is eligible when `mask_i` is 0, or when `mask_i` is 1 and `mask_ui` is 0. While `mask_i` is 0, `mask_ui` has no effect.
- R7: While `mask_i` and `mask_ui` are both 1, only the non-maskable and address-break requests can be taken.
- R8: A request is taken only on a clock edge where `insn_done` is 1. `take` is high for the single cycle after that edge.
- R9: `set_masks` is high in exactly the cycles in which `take` is high.
- R10: `take_vec` holds 7 for the non-maskable request, 8 for address break, and 16+k for maskable source k. It is valid while `take` is high.
- R11: A rising edge on `nmi_in` sets a sticky pending flag. The flag has priority over every other request and is cleared when it is taken. A pulse as short as one cycle is not lost.
- R12: `brk_req` is level-sensitive and bypasses both masks. It ranks below the non-maskable request and above all maskable sources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 16 | Level requests from maskable sources |
| src_en | input | 16 | Per-source enable |
| src_lvl | input | 16 | Per-source priority level (1 = high) |
| nmi_in | input | 1 | Non-maskable request, edge-captured |
| brk_req | input | 1 | Address-break request, level |
| mask_i | input | 1 | Primary mask bit from the core |
| mask_ui | input | 1 | Secondary mask bit from the core |
| insn_done | input | 1 | Instruction-boundary strobe |
| take | output | 1 | Accept pulse |
| take_vec | output | 6 | Vector number of the accepted request |
| set_masks | output | 1 | Command to set both mask bits |

## Verification
The only internal state is the pending flag for the non-maskable request and the registered outputs. A fault in either shows up at the ports one cycle after the next boundary strobe.

A lost edge appears as a missing vector 7. A flag that never clears appears as vector 7 repeating on later boundaries. A wrong eligibility term in the mask gating shows up as a vector from the wrong group, or as a pulse where none should be, on the first boundary that meets the mask combination in question.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_NMI  = 2'd1,
    KIND_BRK  = 2'd2,
    KIND_MASK = 2'd3
  } irq_kind_e;
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic clr,
  output logic pend
);
  logic pin_q;
  logic rise;

  assign rise = pin && !pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      pin_q <= pin;
      pend  <= (pend && !clr) || rise;
    end
  end

  // R11: a held flag survives any cycle in which it was not taken
  p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(pend) && !$past(clr)) |-> pend);
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int NSRC = 16
) (
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] lvl,
  input  logic            mask_i,
  input  logic            mask_ui,
  output logic [NSRC-1:0] elig_hi,
  output logic [NSRC-1:0] elig_lo
);
  logic hi_open;
  logic lo_open;

  assign hi_open = !mask_i || !mask_ui;
  assign lo_open = !mask_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign elig_hi[g] = req[g] && en[g] &&  lvl[g] && hi_open;
    assign elig_lo[g] = req[g] && en[g] && !lvl[g] && lo_open;
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int W = 16,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
    found = |vec;
  end

  // R4: the reported index always points at a set bit
  always_comb begin
    if (found) begin
      p_pick_hit_r4: assert (vec[idx]);
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NSRC     = 16,
  parameter int VW       = 6,
  parameter int VEC_NMI  = 7,
  parameter int VEC_BRK  = 8,
  parameter int VEC_BASE = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_req,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] src_lvl,
  input  logic            nmi_in,
  input  logic            brk_req,
  input  logic            mask_i,
  input  logic            mask_ui,
  input  logic            insn_done,
  output logic            take,
  output logic [VW-1:0]   take_vec,
  output logic            set_masks
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] elig_hi, elig_lo;
  logic            hi_found, lo_found;
  logic [IW-1:0]   hi_idx, lo_idx;
  logic            nmi_pend;
  irq_kind_e       kind;
  logic [VW-1:0]   nxt_vec;
  logic            accept;

  irq_gate #(.NSRC(NSRC)) u_gate (
    .req(src_req), .en(src_en), .lvl(src_lvl),
    .mask_i(mask_i), .mask_ui(mask_ui),
    .elig_hi(elig_hi), .elig_lo(elig_lo)
  );

  irq_pick #(.W(NSRC)) u_pick_hi (
    .vec(elig_hi), .found(hi_found), .idx(hi_idx)
  );

  irq_pick #(.W(NSRC)) u_pick_lo (
    .vec(elig_lo), .found(lo_found), .idx(lo_idx)
  );

  irq_nmi_latch u_nmi (
    .clk(clk), .rst(rst), .pin(nmi_in),
    .clr(accept && (kind == KIND_NMI)), .pend(nmi_pend)
  );

  always_comb begin
    kind    = KIND_NONE;
    nxt_vec = '0;
    if (nmi_pend) begin
      kind    = KIND_NMI;
      nxt_vec = VW'(VEC_NMI);
    end else if (brk_req) begin
      kind    = KIND_BRK;
      nxt_vec = VW'(VEC_BRK);
    end else if (hi_found) begin
      kind    = KIND_MASK;
      nxt_vec = VW'(VEC_BASE) + VW'(hi_idx);
    end else if (lo_found) begin
      kind    = KIND_MASK;
      nxt_vec = VW'(VEC_BASE) + VW'(lo_idx);
    end
  end

  assign accept = insn_done && (kind != KIND_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      take      <= 1'b0;
      set_masks <= 1'b0;
      take_vec  <= '0;
    end else begin
      take      <= accept;
      set_masks <= accept;
      if (accept) take_vec <= nxt_vec;
    end
  end

  // Checking aids: which maskable source the vector names
  logic [NSRC-1:0] acc_hot;
  for (genvar g = 0; g < NSRC; g++) begin : g_hot
    assign acc_hot[g] = (take_vec == VW'(VEC_BASE + g));
  end

  // R8: a pulse only follows a boundary strobe
  p_boundary_r8: assert property (@(posedge clk) disable iff (rst)
    take |-> $past(insn_done));

  // R7: fully masked core sees only the two unmaskable kinds
  p_locked_r7: assert property (@(posedge clk) disable iff (rst)
    (take && $past(mask_i) && $past(mask_ui)) |->
      (take_vec == VW'(VEC_NMI) || take_vec == VW'(VEC_BRK)));

  // R2: an accepted maskable source was requesting and enabled
  p_enabled_r2: assert property (@(posedge clk) disable iff (rst)
    (take && |acc_hot) |-> |(acc_hot & $past(src_req & src_en)));

  // R5: with the primary mask set, only high-level sources pass
  p_lvl0_r5: assert property (@(posedge clk) disable iff (rst)
    (take && |acc_hot && $past(mask_i)) |-> |(acc_hot & $past(src_lvl)));

  // R11: a pending non-maskable request wins the next boundary
  p_nmi_first_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(nmi_pend) && $past(insn_done)) |->
      (take && take_vec == VW'(VEC_NMI)));
endmodule

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
  localparam int CLK_P = 10;
  localparam int NSRC  = 16;
  localparam int VW    = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_req = '0, src_en = '0, src_lvl = '0;
  logic            nmi_in = 1'b0, brk_req = 1'b0;
  logic            mask_i = 1'b0, mask_ui = 1'b0, insn_done = 1'b0;
  logic            take, set_masks;
  logic [VW-1:0]   take_vec;

  int  checks = 0;
  int  errs   = 0;
  bit  m_pend = 0;
  bit  m_prev = 0;
  bit  finished = 0;

  irq_arbiter u0 (
    .clk(clk), .rst(rst), .src_req(src_req), .src_en(src_en),
    .src_lvl(src_lvl), .nmi_in(nmi_in), .brk_req(brk_req),
    .mask_i(mask_i), .mask_ui(mask_ui), .insn_done(insn_done),
    .take(take), .take_vec(take_vec), .set_masks(set_masks)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected choice from the requirements
  task automatic model(output bit v, output int vec);
    v = 0; vec = 0;
    if (m_pend) begin v = 1; vec = 7; end
    else if (brk_req) begin v = 1; vec = 8; end
    else begin
      for (int i = 0; i < NSRC; i++)
        if (!v && src_req[i] && src_en[i] && src_lvl[i] && (!mask_i || !mask_ui)) begin
          v = 1; vec = 16 + i;
        end
      for (int i = 0; i < NSRC; i++)
        if (!v && src_req[i] && src_en[i] && !src_lvl[i] && !mask_i) begin
          v = 1; vec = 16 + i;
        end
    end
  endtask

  task automatic cycle(input string tag);
    bit v; int vec; bit ev;
    model(v, vec);
    ev = v && insn_done;
    @(posedge clk); #1;
    chk({tag, " take"}, int'(take), int'(ev));
    chk({tag, " R9 set_masks"}, int'(set_masks), int'(ev));
    if (ev) chk({tag, " R10 vec"}, int'(take_vec), vec);
    if (ev && vec == 7) m_pend = 0;
    if (nmi_in && !m_prev) m_pend = 1;
    m_prev = nmi_in;
  endtask

  task automatic idle();
    src_req = '0; src_en = '0; src_lvl = '0; brk_req = 0; nmi_in = 0;
    mask_i = 0; mask_ui = 0; insn_done = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; insn_done = 1; nmi_in = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 take in reset", int'(take), 0);
    chk("R1 set_masks in reset", int'(set_masks), 0);
    rst = 0; idle(); insn_done = 1;
    cycle("R1 after reset");

    // R2 disabled source ignored
    src_req = 16'h0001; src_en = 16'h0000; cycle("R2 disabled");
    // R4 lowest index wins inside a level
    src_req = 16'h0028; src_en = 16'hFFFF; src_lvl = '0; cycle("R4 same level");
    // R3 high level beats a lower index of low level
    src_req = 16'h0204; src_lvl = 16'h0200; cycle("R3 high first");
    // R5 low level blocked when mask_i set
    mask_i = 1; mask_ui = 0; src_req = 16'h0004; src_lvl = 0; cycle("R5 blocked");
    // R6 high level passes with mask_ui clear
    src_req = 16'h0200; src_lvl = 16'h0200; cycle("R6 hi passes");
    // R6 mask_ui no effect while mask_i clear
    mask_i = 0; mask_ui = 1; src_req = 16'h0004; src_lvl = 0; cycle("R6 ui ignored");
    // R7 full mask holds maskable
    mask_i = 1; mask_ui = 1; src_req = 16'h0200; src_lvl = 16'h0200; cycle("R7 locked");
    // R12 break bypasses masks
    brk_req = 1; cycle("R12 brk");
    // R8 no boundary, no take
    insn_done = 0; cycle("R8 no boundary");
    // R11 one-cycle pulse held until boundary, beats break
    nmi_in = 1; cycle("R11 edge");
    nmi_in = 0; cycle("R11 hold");
    insn_done = 1; cycle("R11 nmi first");
    cycle("R11 cleared then brk");
    brk_req = 0; cycle("R11 no repeat");
    idle();

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      #1;
      src_req   = NSRC'($urandom & $urandom & $urandom);
      src_en    = NSRC'($urandom | $urandom);
      src_lvl   = NSRC'($urandom);
      mask_i    = 1'($urandom);
      mask_ui   = 1'($urandom);
      insn_done = ($urandom % 3) != 0;
      brk_req   = ($urandom % 16) == 0;
      nmi_in    = ($urandom % 12) == 0;
      cycle("R3 R4 R5 R6 R7 R11 R12 random");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule